// File: doc/BRIEF.md
# DMA Control Register Group with Fixed-Priority Service Selection

This block holds the control side of a four-channel DMA engine: a command byte, a status byte that combines per-channel request flags with per-channel terminal-count flags, a four-bit channel mask, and one stored mode byte per channel. Software reaches it through byte writes and reads on eight control offsets. Peripherals raise and drop service requests through per-channel hold and release inputs. The data-moving part of the engine reports completion of a transfer through a terminal-count strobe.

Every cycle the block looks at all channels whose mask bit is clear and whose request flag is set, and grants the lowest-numbered one. The grant is a one-hot vector that the transfer engine consumes. The stored mode bytes, the command byte and the byte-pointer flag are presented as outputs so that the address and count side can decode them. Status byte layout: bits [7:4] are the request flags of channels 3..0 and bits [3:0] are their terminal-count flags.

Top module: `dmac_ctrl`

## Requirements
- R1: A write to offset 0 loads the command byte only when the data is 0x00 or 0x04; any other value leaves the command output unchanged.
- R2: A write to offset 1 picks channel c = data[1:0], sets the request flag (status bit c+4) to data[2], and always clears the terminal-count flag (status bit c).
- R3: A write to offset 2 picks channel c = data[1:0] and sets its mask bit to data[2] (1 = masked).
- R4: A write to offset 3 stores the whole data byte as the mode of channel data[1:0], shown on mode_o bits [8c+7:8c].
- R5: Reset and a write to offset 5 give mask 0xF, status 0x00, command 0x00 and byte pointer 0; reset also clears all mode bytes.
- R6: A write to offset 4 clears the byte pointer, ptr_toggle_i inverts it, offset 6 clears all mask bits, and offset 7 loads the mask from data[3:0].
- R7: rd_data_o combinationally shows the status byte for offset 0, {4'b0, mask} for offset 1, and 0x00 for offsets 2 to 7; a read of offset 0 clears status bits [3:0] at the clock edge.
- R8: grant_o is one-hot or zero and selects the lowest-numbered channel whose mask bit is clear and whose request flag is set, computed from the current register state.
- R9: hold_i[c] sets the request flag of channel c and release_i[c] clears it; when both are asserted, release wins.
- R10: When tc_i is high, the terminal-count flag of the channel granted in that cycle is set.
- R11: Within one clock the updates apply in this order: status read-clear, hold/release, terminal count, byte-pointer toggle, then the register write, so a register write overrides the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (side effects at edge) |
| offs_i | input | 3 | Control offset |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for offs_i |
| hold_i | input | 4 | Per-channel request raise |
| release_i | input | 4 | Per-channel request drop |
| tc_i | input | 1 | Transfer of the granted channel completed |
| ptr_toggle_i | input | 1 | Byte-pointer toggle from the channel register side |
| grant_o | output | 4 | One-hot service grant |
| cmd_o | output | 8 | Stored command byte |
| mode_o | output | 32 | Mode bytes of channels 3..0 |
| byte_ptr_o | output | 1 | Byte-pointer flag |

## Verification
A corrupted mask or request flag shows on grant_o in the very next cycle, since the grant is decoded from the registers without a further stage; a wrong terminal-count flag stays hidden until software reads offset 0, so reads are mixed densely into the random traffic. A wrong command, mode or pointer value is visible on its output one cycle after the write. Ordering errors between a register write and a simultaneous hold, release or terminal-count event are caught by overlapping those inputs in the same cycle.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    localparam int NCH   = 4;
    localparam int CH_W  = $clog2(NCH);
    localparam int STS_W = 2 * NCH;
    localparam int BYTE  = 8;

    // command values the block accepts besides zero
    localparam logic [BYTE-1:0] CMD_ALLOWED = 8'h04;

    typedef enum logic [2:0] {
        OF_CMD    = 3'd0,
        OF_REQ    = 3'd1,
        OF_ONEMSK = 3'd2,
        OF_MODE   = 3'd3,
        OF_PTRCLR = 3'd4,
        OF_MCLR   = 3'd5,
        OF_UNMASK = 3'd6,
        OF_MSKLD  = 3'd7
    } ctl_ofs_e;

    typedef struct packed {
        logic [STS_W-1:0]           status;
        logic [NCH-1:0]             mask;
        logic [BYTE-1:0]            cmd;
        logic                       ptr;
        logic [NCH-1:0][BYTE-1:0]   mode;
    } ctl_state_t;
endpackage

// File: rtl/dmac_pick.sv
module dmac_pick #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] mask_i,
    output logic [N-1:0] grant_o
);
    logic [N-1:0] elig;
    logic [N:0]   taken;

    assign elig     = req_i & ~mask_i;
    assign taken[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign grant_o[i]   = elig[i] & ~taken[i];
        assign taken[i + 1] = taken[i] | elig[i];
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o)); // R8
    AST_GRANT_WHEN_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
        (elig != '0) |-> (grant_o != '0)); // R8
endmodule

// File: rtl/dmac_regs.sv
module dmac_regs
    import dmac_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic                 rd_en_i,
    input  logic [2:0]           offs_i,
    input  logic [BYTE-1:0]      wr_data_i,
    input  logic [NCH-1:0]       hold_i,
    input  logic [NCH-1:0]       release_i,
    input  logic                 tc_i,
    input  logic                 ptr_toggle_i,
    input  logic [NCH-1:0]       grant_i,
    output logic [BYTE-1:0]      rd_data_o,
    output ctl_state_t           state_o
);
    ctl_state_t st_q, st_d;
    logic [CH_W-1:0] sel_ch;
    logic            cmd_ok;

    assign sel_ch = wr_data_i[CH_W-1:0];
    assign cmd_ok = (wr_data_i == '0) || ((wr_data_i & ~CMD_ALLOWED) == '0);

    always_comb begin
        st_d = st_q;
        if (rd_en_i && offs_i == OF_CMD)
            st_d.status[NCH-1:0] = '0;
        st_d.status[STS_W-1:NCH] = (st_d.status[STS_W-1:NCH] | hold_i) & ~release_i;
        if (tc_i)
            st_d.status[NCH-1:0] = st_d.status[NCH-1:0] | grant_i;
        if (ptr_toggle_i)
            st_d.ptr = ~st_q.ptr;
        if (wr_en_i) begin
            case (ctl_ofs_e'(offs_i))
                OF_CMD:    if (cmd_ok) st_d.cmd = wr_data_i;
                OF_REQ: begin
                    st_d.status[NCH + int'(sel_ch)] = wr_data_i[2];
                    st_d.status[int'(sel_ch)]       = 1'b0;
                end
                OF_ONEMSK: st_d.mask[sel_ch] = wr_data_i[2];
                OF_MODE:   st_d.mode[sel_ch] = wr_data_i;
                OF_PTRCLR: st_d.ptr = 1'b0;
                OF_MCLR: begin
                    st_d.ptr    = 1'b0;
                    st_d.mask   = '1;
                    st_d.status = '0;
                    st_d.cmd    = '0;
                end
                OF_UNMASK: st_d.mask = '0;
                OF_MSKLD:  st_d.mask = wr_data_i[NCH-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (ctl_ofs_e'(offs_i))
            OF_CMD:    rd_data_o = st_q.status;
            OF_REQ:    rd_data_o = {{(BYTE-NCH){1'b0}}, st_q.mask};
            default:   rd_data_o = '0;
        endcase
    end

    assign state_o = st_q;

    AST_CMD_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && offs_i == OF_CMD && !cmd_ok) |=> $stable(st_q.cmd)); // R1
    AST_MCLR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && offs_i == OF_MCLR) |=> (st_q.mask == '1 && st_q.status == '0 && st_q.cmd == '0)); // R5
    AST_RDCLR_TC: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && offs_i == OF_CMD && !tc_i && !(wr_en_i && offs_i == OF_MSKLD)) |=> (st_q.status[NCH-1:0] == '0)); // R7
    AST_TC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_i && !wr_en_i && grant_i != '0) |=> ((st_q.status[NCH-1:0] & $past(grant_i)) != '0)); // R10
endmodule

// File: rtl/dmac_ctrl.sv
module dmac_ctrl
    import dmac_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en_i,
    input  logic        rd_en_i,
    input  logic [2:0]  offs_i,
    input  logic [7:0]  wr_data_i,
    output logic [7:0]  rd_data_o,
    input  logic [3:0]  hold_i,
    input  logic [3:0]  release_i,
    input  logic        tc_i,
    input  logic        ptr_toggle_i,
    output logic [3:0]  grant_o,
    output logic [7:0]  cmd_o,
    output logic [31:0] mode_o,
    output logic        byte_ptr_o
);
    ctl_state_t      st;
    logic [NCH-1:0]  grant;

    dmac_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en_i),
        .rd_en_i      (rd_en_i),
        .offs_i       (offs_i),
        .wr_data_i    (wr_data_i),
        .hold_i       (hold_i),
        .release_i    (release_i),
        .tc_i         (tc_i),
        .ptr_toggle_i (ptr_toggle_i),
        .grant_i      (grant),
        .rd_data_o    (rd_data_o),
        .state_o      (st)
    );

    dmac_pick #(.N(NCH)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (st.status[STS_W-1:NCH]),
        .mask_i  (st.mask),
        .grant_o (grant)
    );

    assign grant_o    = grant;
    assign cmd_o      = st.cmd;
    assign mode_o     = st.mode;
    assign byte_ptr_o = st.ptr;

    AST_GRANT_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & st.mask) == '0); // R8
    AST_RELEASE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (release_i != '0 && !wr_en_i) |=> ((st.status[STS_W-1:NCH] & $past(release_i)) == '0)); // R9
endmodule

// File: tb/dmac_ctrl_tb_top.sv
`timescale 1ns/1ps
module dmac_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, tc = 1'b0, ptr_t = 1'b0;
    logic [2:0]  offs = '0;
    logic [7:0]  wdata = '0;
    logic [3:0]  hold = '0, rel = '0;
    logic [7:0]  rdata, cmd;
    logic [3:0]  grant;
    logic [31:0] mode;
    logic        bptr;

    int checks = 0;
    int errors = 0;

    // reference state
    logic [7:0] m_status;
    logic [3:0] m_mask;
    logic [7:0] m_cmd;
    logic       m_ptr;
    logic [7:0] m_mode [4];

    always #4 clk = ~clk;

    dmac_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .offs_i(offs), .wr_data_i(wdata), .rd_data_o(rdata),
        .hold_i(hold), .release_i(rel), .tc_i(tc), .ptr_toggle_i(ptr_t),
        .grant_o(grant), .cmd_o(cmd), .mode_o(mode), .byte_ptr_o(bptr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_grant();
        logic [3:0] e = m_status[7:4] & ~m_mask;
        for (int i = 0; i < 4; i++)
            if (e[i]) return 4'(1 << i);
        return 4'h0;
    endfunction

    function automatic logic [7:0] exp_read(input logic [2:0] o);
        if (o == 3'd0) return m_status;
        if (o == 3'd1) return {4'h0, m_mask};
        return 8'h00;
    endfunction

    task automatic model_reset();
        m_status = '0; m_mask = 4'hF; m_cmd = '0; m_ptr = 1'b0;
        for (int i = 0; i < 4; i++) m_mode[i] = '0;
    endtask

    task automatic model_next();
        logic [3:0] g = exp_grant();
        logic [1:0] c = wdata[1:0];
        if (rd_en && offs == 3'd0) m_status[3:0] = 4'h0;
        m_status[7:4] = (m_status[7:4] | hold) & ~rel;
        if (tc) m_status[3:0] = m_status[3:0] | g;
        if (ptr_t) m_ptr = ~m_ptr;
        if (wr_en) begin
            case (offs)
                3'd0: if (wdata == 8'h00 || wdata == 8'h04) m_cmd = wdata;
                3'd1: begin m_status[4 + c] = wdata[2]; m_status[c] = 1'b0; end
                3'd2: m_mask[c] = wdata[2];
                3'd3: m_mode[c] = wdata;
                3'd4: m_ptr = 1'b0;
                3'd5: begin m_ptr = 1'b0; m_mask = 4'hF; m_status = '0; m_cmd = '0; end
                3'd6: m_mask = 4'h0;
                default: m_mask = wdata[3:0];
            endcase
        end
    endtask

    task automatic check_outputs();
        check("R8 grant", {28'h0, grant}, {28'h0, exp_grant()});
        check("R1 cmd", {24'h0, cmd}, {24'h0, m_cmd});
        check("R4 mode", mode, {m_mode[3], m_mode[2], m_mode[1], m_mode[0]});
        check("R6 ptr", {31'h0, bptr}, {31'h0, m_ptr});
    endtask

    // one clock of stimulus: outputs checked, inputs driven, read checked, model advanced
    task automatic step(input logic w, input logic r, input logic [2:0] o, input logic [7:0] d,
                        input logic [3:0] h, input logic [3:0] rl, input logic t, input logic pt);
        @(negedge clk);
        check_outputs();
        wr_en = w; rd_en = r; offs = o; wdata = d; hold = h; rel = rl; tc = t; ptr_t = pt;
        #1;
        check("R7 rdata", {24'h0, rdata}, {24'h0, exp_read(o)});
        model_next();
        @(posedge clk);
        #1;
        wr_en = 0; rd_en = 0; hold = 0; rel = 0; tc = 0; ptr_t = 0;
    endtask

    task automatic wr(input logic [2:0] o, input logic [7:0] d);
        step(1'b1, 1'b0, o, d, 4'h0, 4'h0, 1'b0, 1'b0);
    endtask

    task automatic rd_expect(input logic [2:0] o, input logic [7:0] exp, input string tag);
        @(negedge clk);
        offs = o; rd_en = 1'b1;
        #1;
        check(tag, {24'h0, rdata}, {24'h0, exp});
        model_next();
        @(posedge clk);
        #1;
        rd_en = 1'b0;
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 3'd2, 8'h00, 4'h0, 4'h0, 1'b0, 1'b0);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R5: state after reset
        check("R5 reset grant", {28'h0, grant}, 32'h0);
        check("R5 reset cmd", {24'h0, cmd}, 32'h0);
        check("R5 reset mode", mode, 32'h0);
        rd_expect(3'd1, 8'h0F, "R5 reset mask");
        rd_expect(3'd0, 8'h00, "R5 reset status");

        // R1: command filter
        wr(3'd0, 8'h01); idle();
        check("R1 reject 01", {24'h0, cmd}, 32'h0);
        wr(3'd0, 8'h04); idle();
        check("R1 accept 04", {24'h0, cmd}, 32'h4);
        wr(3'd0, 8'h84); idle();
        check("R1 reject 84", {24'h0, cmd}, 32'h4);

        // R3, R2, R8: unmask ch2 and ch1, raise requests
        wr(3'd2, 8'h02); wr(3'd1, 8'h06); idle();
        check("R2 R8 grant ch2", {28'h0, grant}, 32'h4);
        wr(3'd2, 8'h01); wr(3'd1, 8'h05); idle();
        check("R8 lowest wins", {28'h0, grant}, 32'h2);
        // R10: terminal count on ch1
        step(1'b0, 1'b0, 3'd2, 8'h00, 4'h0, 4'h0, 1'b1, 1'b0);
        rd_expect(3'd0, 8'h62, "R10 R7 status with tc");
        rd_expect(3'd0, 8'h60, "R7 tc nibble cleared");
        step(1'b0, 1'b0, 3'd2, 8'h00, 4'h0, 4'h0, 1'b1, 1'b0);
        wr(3'd1, 8'h05);
        rd_expect(3'd0, 8'h60, "R2 request write clears tc");

        // R9: external hold/release
        step(1'b0, 1'b0, 3'd2, 8'h00, 4'h1, 4'h0, 1'b0, 1'b0); idle();
        check("R9 masked hold no grant", {28'h0, grant}, 32'h2);
        step(1'b0, 1'b0, 3'd2, 8'h00, 4'h0, 4'h2, 1'b0, 1'b0); idle();
        check("R9 release ch1", {28'h0, grant}, 32'h4);
        step(1'b0, 1'b0, 3'd2, 8'h00, 4'h8, 4'h8, 1'b0, 1'b0);
        rd_expect(3'd0, 8'h50, "R9 release beats hold");

        // R11: write overrides same-cycle hold
        wr(3'd2, 8'h00);
        step(1'b1, 1'b0, 3'd1, 8'h00, 4'h1, 4'h0, 1'b0, 1'b0); idle();
        check("R11 write over hold", {28'h0, grant}, 32'h4);

        // R6: mask load, clear all, pointer
        wr(3'd7, 8'h0F); idle();
        check("R6 mask load", {28'h0, grant}, 32'h0);
        rd_expect(3'd1, 8'h0F, "R6 mask read");
        wr(3'd6, 8'h00); idle();
        check("R6 unmask all", {28'h0, grant}, 32'h4);
        step(1'b0, 1'b0, 3'd2, 8'h00, 4'h0, 4'h0, 1'b0, 1'b1); idle();
        check("R6 ptr toggled", {31'h0, bptr}, 32'h1);
        wr(3'd4, 8'h00); idle();
        check("R6 ptr cleared", {31'h0, bptr}, 32'h0);

        // R4: mode byte
        wr(3'd3, 8'hA7); idle();
        check("R4 mode ch3", {24'h0, mode[31:24]}, 32'hA7);
        rd_expect(3'd3, 8'h00, "R7 other offset zero");

        // R5: master clear
        wr(3'd5, 8'h00); idle();
        check("R5 mclr grant", {28'h0, grant}, 32'h0);
        rd_expect(3'd1, 8'h0F, "R5 mclr mask");
        rd_expect(3'd0, 8'h00, "R5 mclr status");

        // random traffic (R11 ordering exercised by overlaps)
        for (int n = 0; n < 5000; n++) begin
            logic [7:0] d;
            logic [2:0] o;
            o = 3'($urandom % 8);
            if (o == 3'd5 && ($urandom % 4) != 0) o = 3'd1;
            d = 8'($urandom);
            if (o == 3'd0 && $urandom % 2 == 1) d = (($urandom % 2) == 1) ? 8'h04 : 8'h00;
            step(($urandom % 2) == 1, ($urandom % 3) == 0, o, d,
                 (($urandom % 4) == 0) ? 4'($urandom) : 4'h0,
                 (($urandom % 5) == 0) ? 4'($urandom) : 4'h0,
                 ($urandom % 3) == 0, ($urandom % 6) == 0);
        end
        idle();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule